// File: doc/BRIEF.md
# Ternary Static Hazard Detector

This block tests a small programmable sum-of-products function for glitches that can appear while its inputs move from one binary vector to another. The function is a set of product terms. For each term, one enable bit and two bits per input (whether the input takes part, and whether it appears true or complemented) configure it.

Once a check is accepted, the block evaluates the function in three-valued logic (0, 1, X) over three cycles. The first evaluation uses the old vector. The second uses an intermediate vector in which every input that differs between old and new is unknown. The third uses the new vector. If old and new results agree but the intermediate result is unknown, the output may pulse, and a static hazard is flagged. If they differ and the intermediate result is unknown, the output may toggle more than once, and a possible dynamic hazard is flagged. The three results and the two flags appear together with a one-cycle valid pulse.

Top module: `hazard_probe`

## Requirements
- R1: After reset, `busy`, `valid`, `static_haz` and `dynamic_haz` are all 0.
- R2: A check is accepted on a clock edge where `start` is 1 and `busy` is 0. While `busy` is 1, `start` and the vectors presented with it have no effect on any result.
- R3: `busy` is 1 for exactly three cycles after the accepting edge. `valid` is 1 for exactly one cycle, which begins on the third edge after the accepting edge, the same edge where `busy` falls.
- R4: A product term is 0 if any of its literals is 0. Otherwise it is X if any literal is X. Otherwise it is 1. For term t and input i, the bit index is t*N_IN+i. `cfg_care` bit 1 puts the input in the term. `cfg_pol` bit 1 selects the true literal and bit 0 selects the complemented literal.
- R5: The function output is 1 if any term is 1. Otherwise it is X if any term is X. Otherwise it is 0. `f_old` and `f_new` give the binary results for the old (`vec_a`) and new (`vec_b`) vectors. `mid_x` is 1 when the intermediate result is X.
- R6: In the intermediate vector, every input that differs between `vec_a` and `vec_b` is X, and every other input keeps its common value.
- R7: `static_haz` is 1 in the valid cycle exactly when `f_old` equals `f_new` and `mid_x` is 1.
- R8: `dynamic_haz` is 1 in the valid cycle exactly when `f_old` differs from `f_new` and `mid_x` is 1.
- R9: When `vec_a` equals `vec_b`, neither hazard flag is raised.
- R10: Outside the valid cycle, `static_haz` and `dynamic_haz` are 0.
- R11: A term whose `cfg_use` bit is 0 contributes 0. An enabled term with no inputs selected is constant 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_use | input | N_TERM | Enable bit for each product term |
| cfg_care | input | N_TERM*N_IN | Input-selection bits for each term |
| cfg_pol | input | N_TERM*N_IN | Literal polarity, 1 = true, 0 = complemented |
| start | input | 1 | Request a check |
| vec_a | input | N_IN | Old input vector |
| vec_b | input | N_IN | New input vector |
| busy | output | 1 | A check is in progress |
| valid | output | 1 | One-cycle result strobe |
| f_old | output | 1 | Function value on the old vector |
| f_new | output | 1 | Function value on the new vector |
| mid_x | output | 1 | Intermediate evaluation is unknown |
| static_haz | output | 1 | Static hazard flag |
| dynamic_haz | output | 1 | Possible dynamic hazard flag |

## Verification
The assertions assume that the configuration inputs do not change between acceptance and the valid cycle. The vectors are captured at acceptance, but the configuration is read live in each phase. The bench therefore changes the configuration only while the block is idle. It also raises `start` again during busy cycles, with different vectors, to show that those requests are dropped. Directed cases cover the classic two-term hazard, a single toggling literal, equal vectors, an empty enabled term and an all-disabled function. Randomised functions and vector pairs then follow.

// File: rtl/hazard_probe.sv
module hazard_probe #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_TERM-1:0]        cfg_use,
  input  logic [N_TERM*N_IN-1:0]   cfg_care,
  input  logic [N_TERM*N_IN-1:0]   cfg_pol,
  input  logic                     start,
  input  logic [N_IN-1:0]          vec_a,
  input  logic [N_IN-1:0]          vec_b,
  output logic                     busy,
  output logic                     valid,
  output logic                     f_old,
  output logic                     f_new,
  output logic                     mid_x,
  output logic                     static_haz,
  output logic                     dynamic_haz
);

  typedef enum logic [1:0] {S_IDLE, S_OLD, S_MID, S_NEW} phase_t;
  phase_t phase;

  logic [N_IN-1:0] a_q, b_q;
  logic [N_IN-1:0] cur_v, cur_x;
  logic [N_TERM-1:0] t_zero, t_x, t_one;
  logic ev_one, ev_x;
  logic r_old, r_mid_x;

  always_comb begin
    cur_v = a_q;
    cur_x = '0;
    if (phase == S_MID) cur_x = a_q ^ b_q;
    if (phase == S_NEW) cur_v = b_q;
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] care, pol;
    assign care     = cfg_care[t*N_IN +: N_IN];
    assign pol      = cfg_pol[t*N_IN +: N_IN];
    assign t_zero[t] = ~cfg_use[t] | (|(care & ~cur_x & (cur_v ^ pol)));
    assign t_x[t]    = ~t_zero[t] & (|(care & cur_x));
    assign t_one[t]  = ~t_zero[t] & ~t_x[t];
  end

  assign ev_one = |t_one;
  assign ev_x   = ~ev_one & (|t_x);
  assign busy   = (phase != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= S_IDLE;
      a_q         <= '0;
      b_q         <= '0;
      r_old       <= 1'b0;
      r_mid_x     <= 1'b0;
      valid       <= 1'b0;
      f_old       <= 1'b0;
      f_new       <= 1'b0;
      mid_x       <= 1'b0;
      static_haz  <= 1'b0;
      dynamic_haz <= 1'b0;
    end else begin
      valid       <= 1'b0;
      static_haz  <= 1'b0;
      dynamic_haz <= 1'b0;
      case (phase)
        S_IDLE: if (start) begin
          a_q   <= vec_a;
          b_q   <= vec_b;
          phase <= S_OLD;
        end
        S_OLD: begin
          r_old <= ev_one;
          phase <= S_MID;
        end
        S_MID: begin
          r_mid_x <= ev_x;
          phase   <= S_NEW;
        end
        default: begin
          valid       <= 1'b1;
          f_old       <= r_old;
          f_new       <= ev_one;
          mid_x       <= r_mid_x;
          static_haz  <= r_mid_x & (r_old == ev_one);
          dynamic_haz <= r_mid_x & (r_old != ev_one);
          phase       <= S_IDLE;
        end
      endcase
    end
  end

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_valid_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(busy) && !busy);
  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  assert_static_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    static_haz |-> (f_old == f_new) && mid_x);
  assert_dynamic_differ_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dynamic_haz |-> (f_old != f_new) && mid_x);
  assert_flags_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !static_haz && !dynamic_haz);

endmodule

// File: tb/tb_hazard_probe.sv
module tb_hazard_probe;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]    cfg_use = '0;
  logic [NT*NI-1:0] cfg_care = '0;
  logic [NT*NI-1:0] cfg_pol = '0;
  logic start = 1'b0;
  logic [NI-1:0] vec_a = '0, vec_b = '0;
  logic busy, valid, f_old, f_new, mid_x, static_haz, dynamic_haz;

  int n_checks = 0, n_fail = 0, pend = 0, cycles = 0;
  int e_fo, e_fn, e_mx, e_st, e_dy;

  hazard_probe #(.N_IN(NI), .N_TERM(NT)) dut (
    .clk, .rst_n, .cfg_use, .cfg_care, .cfg_pol, .start, .vec_a, .vec_b,
    .busy, .valid, .f_old, .f_new, .mid_x, .static_haz, .dynamic_haz);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // returns 0, 1 or 2 (=X)
  function automatic int teval(input logic [NI-1:0] v, input logic [NI-1:0] xm);
    int res = 0;
    for (int t = 0; t < NT; t++) begin
      int tv = 1;
      if (!cfg_use[t]) tv = 0;
      else
        for (int i = 0; i < NI; i++)
          if (cfg_care[t*NI+i]) begin
            if (xm[i]) begin if (tv == 1) tv = 2; end
            else if ((cfg_pol[t*NI+i] ? v[i] : !v[i]) == 1'b0) tv = 0;
            if (tv == 0) break;
          end
      if (tv == 1) res = 1;
      else if (tv == 2 && res == 0) res = 2;
    end
    return res;
  endfunction

  task automatic step(input bit s, input logic [NI-1:0] a, input logic [NI-1:0] b);
    int was;
    @(negedge clk);
    cycles++;
    was = pend;
    if (pend > 0) pend--;
    check("R3 valid", int'(valid), int'(was == 1));
    check("R2 busy", int'(busy), int'(pend > 0));
    if (was == 1) begin
      check("R4 f_old", int'(f_old), e_fo);
      check("R5 f_new", int'(f_new), e_fn);
      check("R6 mid_x", int'(mid_x), e_mx);
      check("R7 static_haz", int'(static_haz), e_st);
      check("R8 dynamic_haz", int'(dynamic_haz), e_dy);
    end else begin
      check("R10 static idle", int'(static_haz), 0);
      check("R10 dynamic idle", int'(dynamic_haz), 0);
    end
    start = s; vec_a = a; vec_b = b;
    if (s && pend == 0) begin
      int m;
      e_fo = teval(a, '0);
      e_fn = teval(b, '0);
      m    = teval(a, a ^ b);
      e_mx = int'(m == 2);
      e_st = int'(m == 2 && e_fo == e_fn);
      e_dy = int'(m == 2 && e_fo != e_fn);
      pend = 4;
    end
  endtask

  task automatic run_case(input logic [NT-1:0] u, input logic [NT*NI-1:0] c,
                          input logic [NT*NI-1:0] p, input logic [NI-1:0] a,
                          input logic [NI-1:0] b);
    cfg_use = u; cfg_care = c; cfg_pol = p;
    step(1'b1, a, b);
    step(1'b1, ~a, a);   // R2: ignored while busy
    step(1'b1, b, ~b);
    step(1'b0, '0, '0);
    step(1'b0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 valid", int'(valid), 0);
    check("R1 static", int'(static_haz), 0);
    check("R1 dynamic", int'(dynamic_haz), 0);
    rst_n = 1'b1;
    // R7: x0&x1 | ~x0&x2 with x1=x2=1, x0 falls
    run_case(8'h03, {48'h0, 8'h05, 8'h03}, {48'h0, 8'h04, 8'h03}, 8'h07, 8'h06);
    if (!(e_st == 1 && e_mx == 1)) begin n_fail++; $display("FAIL R7 directed model"); end
    // R8: f = x0, x0 rises
    run_case(8'h01, {56'h0, 8'h01}, {56'h0, 8'h01}, 8'h00, 8'h01);
    // R9: equal vectors
    run_case(8'h03, {48'h0, 8'h05, 8'h03}, {48'h0, 8'h04, 8'h03}, 8'h5A, 8'h5A);
    // R11: enabled empty term -> 1; all disabled -> 0
    run_case(8'h04, '0, '0, 8'h00, 8'hFF);
    run_case(8'h00, '1, '1, 8'h0F, 8'hF0);
    // R4 R5: hazard covered by consensus term x1&x2
    run_case(8'h07, {40'h0, 8'h06, 8'h05, 8'h03}, {40'h0, 8'h06, 8'h04, 8'h03}, 8'h07, 8'h06);
    for (int k = 0; k < 400; k++) begin
      logic [NT*NI-1:0] c;
      logic [NI-1:0] a, b;
      c = {$urandom, $urandom} & {$urandom, $urandom};
      a = NI'($urandom);
      b = (k % 4 == 0) ? a : (a ^ NI'($urandom & $urandom));
      run_case(NT'($urandom), c, {$urandom, $urandom}, a, b);
    end
    step(1'b0, '0, '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule